// File: doc/BRIEF.md
# Button-Stepped Square-Wave Generator

This block drives a square wave whose frequency, in kHz, equals an 8-bit setting in the range 0 to 255. Two push buttons change the setting, one up and one down. Each press moves the setting by one. A button held past a hold time, one second by default, makes the setting keep stepping at a fixed repeat rate, one step every 100 ms by default, until the button is let go. The setting is also driven in plain binary onto eight LED outputs, so the operator can read the frequency directly.

Each button passes through a two-flop synchronizer and a debounce filter. The filter accepts a new level only after the input has stayed at that level for a set time. The wave comes from the top bit of a 32-bit phase accumulator. Its increment is derived each cycle from the setting with a constant multiplier computed from the clock frequency. A new setting therefore changes the pitch on the next cycle and keeps the running phase. All registers switch on the rising clock edge and share one synchronous reset.

Top module: `pulse_gen`

## Requirements
- R1: While reset is asserted, the setting, all timers and the accumulator are cleared. On the first cycle after a reset cycle, `led_o` is 0 and `wave_o` is low.
- R2: `led_o` carries the setting in binary, with bit 0 on `led_o[0]`. For example, a setting of 5 lights `led_o[0]` and `led_o[2]` only.
- R3: A button level is accepted only after the synchronized input has been stable for DEB_US microseconds. A shorter pulse, or a bouncing burst, yields no step beyond the one due to the final settled level.
- R4: Each accepted press of the up button raises the setting by exactly one, and each accepted press of the down button lowers it by exactly one. The step comes immediately after the press is accepted, and the setting never moves by more than one per cycle.
- R5: While a single button stays held, one extra step occurs HOLD_US after acceptance. After that, one step occurs every REP_US until the release is accepted. No step occurs before the hold time ends.
- R6: The setting saturates at 255 going up and at 0 going down. It never wraps.
- R7: While both buttons are held, the setting does not change.
- R8: The rate of rising edges on `wave_o` equals the setting in kHz, within one edge per measurement window, and the duty cycle is close to half. The rate follows a new setting without a reset of the phase.
- R9: While the setting is 0, `wave_o` stays low and the accumulator is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of frequency CLK_HZ; rising edge used |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_up_i | input | 1 | Raw increment button, active high |
| btn_dn_i | input | 1 | Raw decrement button, active high |
| led_o | output | 8 | Current frequency setting in kHz, binary |
| wave_o | output | 1 | Square-wave output |

## Verification
From an input edge, the debounced level changes after two synchronizer cycles plus DEB_US worth of cycles. The setting moves one cycle later. Hold and repeat steps then follow at HOLD_US and REP_US from that point. The bench places every sample at least 40 cycles away from any predicted step, so small differences in register latency cannot move a result across a boundary. The frequency is checked by counting rising edges over windows of thousands of cycles, sampled on the falling clock edge. This allows a tolerance of one edge for the unknown starting phase.

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int DEB_US  = 5_000,
  parameter int HOLD_US = 1_000_000,
  parameter int REP_US  = 100_000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       btn_up_i,
  input  logic       btn_dn_i,
  output logic [7:0] led_o,
  output logic       wave_o
);

  localparam longint DEB_C  = longint'(CLK_HZ) * DEB_US / 1_000_000;
  localparam longint HOLD_C = longint'(CLK_HZ) * HOLD_US / 1_000_000;
  localparam longint REP_C  = longint'(CLK_HZ) * REP_US / 1_000_000;
  localparam longint TMAX   = (HOLD_C > REP_C) ? HOLD_C : REP_C;
  localparam int     DW     = $clog2(DEB_C + 1);
  localparam int     TW     = $clog2(TMAX + 1);
  localparam int     FB     = 16;
  localparam longint KSTEP  = (longint'(1000) << (32 + FB)) / CLK_HZ;

  logic [1:0] raw;
  logic [1:0] lvl;
  assign raw = {btn_dn_i, btn_up_i};

  for (genvar i = 0; i < 2; i++) begin : g_deb
    logic [1:0]    sync;
    logic [DW-1:0] cnt;
    logic          q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        sync <= '0;
        cnt  <= '0;
        q    <= 1'b0;
      end else begin
        sync <= {sync[0], raw[i]};
        if (sync[1] == q) begin
          cnt <= '0;
        end else if (cnt == DW'(DEB_C - 1)) begin
          cnt <= '0;
          q   <= sync[1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign lvl[i] = q;
  end

  logic [1:0]    dir, dir_q;
  logic          held, fresh, tick, rep;
  logic [TW-1:0] tmr;
  logic [7:0]    setting;

  assign dir   = {lvl[1] & ~lvl[0], lvl[0] & ~lvl[1]};
  assign held  = |dir;
  assign fresh = |(dir & ~dir_q);

  always_comb begin
    tick = 1'b0;
    if (held && !fresh) begin
      if (!rep && tmr == TW'(HOLD_C - 1)) tick = 1'b1;
      if (rep && tmr == TW'(REP_C - 1))   tick = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dir_q   <= '0;
      tmr     <= '0;
      rep     <= 1'b0;
      setting <= '0;
    end else begin
      dir_q <= dir;
      if (!held || fresh) begin
        tmr <= '0;
        rep <= 1'b0;
      end else if (tick) begin
        tmr <= '0;
        rep <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
      if ((fresh || tick) && dir[0] && setting != 8'hFF) setting <= setting + 8'd1;
      if ((fresh || tick) && dir[1] && setting != 8'h00) setting <= setting - 8'd1;
    end
  end

  logic [63:0] prod;
  logic [31:0] acc;
  assign prod = 64'(setting) * 64'(KSTEP);

  always_ff @(posedge clk_i) begin
    if (rst_i || setting == 8'd0) acc <= '0;
    else                          acc <= acc + prod[FB+31:FB];
  end

  assign led_o  = setting;
  assign wave_o = acc[31];

endmodule

// File: rtl/pulse_gen_chk.sv
module pulse_gen_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic [7:0] led_o,
  input logic       wave_o,
  input logic       up_lvl,
  input logic       dn_lvl
);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (led_o == 8'd0 && !wave_o));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!up_lvl && !dn_lvl) |=> $stable(led_o));

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ({1'b0, led_o} == {1'b0, $past(led_o)} ||
              {1'b0, led_o} == {1'b0, $past(led_o)} + 9'd1 ||
              {1'b0, led_o} + 9'd1 == {1'b0, $past(led_o)}));

  assert_no_wrap_top_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (led_o == 8'hFF) |=> (led_o != 8'h00));

  assert_no_wrap_bot_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (led_o == 8'h00) |=> (led_o != 8'hFF));

  assert_both_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (up_lvl && dn_lvl) |=> $stable(led_o));

  assert_zero_low_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (led_o == 8'd0) |=> !wave_o);

endmodule

bind pulse_gen pulse_gen_chk u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .led_o  (led_o),
  .wave_o (wave_o),
  .up_lvl (lvl[0]),
  .dn_lvl (lvl[1])
);

// File: tb/pulse_gen_tb.sv
module pulse_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int F_HZ = 1_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0;
  logic dn = 1'b0;
  logic [7:0] led;
  logic wave;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pulse_gen #(.CLK_HZ(F_HZ), .DEB_US(50), .HOLD_US(2000), .REP_US(100)) u_dut (
    .clk_i(clk), .rst_i(rst), .btn_up_i(up), .btn_dn_i(dn), .led_o(led), .wave_o(wave)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    check(led == 8'd0, "R1 setting after reset", led, 0);
    check(wave == 1'b0, "R1 wave after reset", wave, 0);
  endtask

  task automatic t_glitch;
    int s0 = led;
    up = 1'b1; wait_cyc(30); up = 1'b0;
    wait_cyc(200);
    check(led == s0[7:0], "R3 short pulse ignored", led, s0);
    for (int k = 0; k < 10; k++) begin
      up = ~up; wait_cyc(20);
    end
    up = 1'b1; wait_cyc(300); up = 1'b0;
    wait_cyc(200);
    check(int'(led) == s0 + 1, "R3 bouncing press gives one step", led, s0 + 1);
  endtask

  task automatic t_tap(input bit go_up, input int exp, input string req);
    if (go_up) up = 1'b1; else dn = 1'b1;
    wait_cyc(300);
    up = 1'b0; dn = 1'b0;
    wait_cyc(150);
    check(int'(led) == exp, req, led, exp);
  endtask

  task automatic t_both;
    int s0 = led;
    up = 1'b1; dn = 1'b1;
    wait_cyc(3000);
    up = 1'b0; dn = 1'b0;
    wait_cyc(200);
    check(int'(led) == s0, "R7 both held no change", led, s0);
  endtask

  task automatic t_freq(input int win, input string req);
    int rises = 0;
    int highs = 0;
    int exp, per;
    logic prev = wave;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (wave && !prev) rises++;
      if (wave) highs++;
      prev = wave;
    end
    exp = win * int'(led) / 1000;
    check(rises >= exp - 1 && rises <= exp + 1, req, rises, exp);
    if (led != 0) begin
      per = 1000 / int'(led) + 1;
      check(highs >= win / 2 - per && highs <= win / 2 + per, "R8 duty near half", highs, win / 2);
    end else begin
      check(highs == 0, "R9 setting zero keeps wave low", highs, 0);
    end
  endtask

  task automatic t_hold;
    int s0 = led;
    up = 1'b1;
    wait_cyc(1000);
    check(int'(led) == s0 + 1, "R5 no repeat before hold time", led, s0 + 1);
    wait_cyc(1104);
    check(int'(led) == s0 + 2, "R5 first repeat at hold time", led, s0 + 2);
    wait_cyc(300);
    check(int'(led) == s0 + 5, "R5 repeat every interval", led, s0 + 5);
    wait_cyc(46);
    up = 1'b0;
    wait_cyc(300);
    check(int'(led) == s0 + 6, "R5 stepping stops on release", led, s0 + 6);
    wait_cyc(500);
    check(int'(led) == s0 + 6, "R5 stable after release", led, s0 + 6);
  endtask

  task automatic t_saturate(input bit go_up);
    if (go_up) up = 1'b1; else dn = 1'b1;
    wait_cyc(28100);
    if (go_up) check(led == 8'hFF, "R6 saturate at 255", led, 255);
    else       check(led == 8'h00, "R6 saturate at 0", led, 0);
    up = 1'b0; dn = 1'b0;
    wait_cyc(200);
    if (go_up) check(led == 8'hFF, "R6 held at 255 after release", led, 255);
    else       check(led == 8'h00, "R6 held at 0 after release", led, 0);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_tap(1'b1, 2, "R4 up step");
    t_tap(1'b1, 3, "R4 up step");
    t_tap(1'b1, 4, "R4 up step");
    t_tap(1'b1, 5, "R4 up step");
    check(led == 8'b0000_0101, "R2 binary LED pattern", led, 5);
    t_tap(1'b0, 4, "R4 down step");
    t_tap(1'b1, 5, "R4 up step");
    t_both();
    t_freq(4000, "R8 rate at 5 kHz");
    t_hold();
    t_freq(4000, "R8 rate tracks new setting 11 kHz");
    t_saturate(1'b1);
    t_tap(1'b1, 255, "R6 up press at 255 ignored");
    t_freq(2000, "R8 rate at 255 kHz");
    t_saturate(1'b0);
    t_tap(1'b0, 0, "R6 down press at 0 ignored");
    t_freq(1000, "R9 zero setting");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule